// File: doc/BRIEF.md
# Bridge Window Control Register Bank

This block is the register bank of a host-to-PCI bridge. It stores four sets of address-window settings and one bridge control word. Each set has a window base, a window size mask and a translated base. All registers are 64 bits wide. They are reached over a simple valid/ready request bus. Each accepted request gets exactly one registered response one cycle later, carrying read data and an error flag.

A register's index is the byte offset of the access shifted right by six, so each register owns a 64-byte slot. Several diagnostic registers read as zero. Some of them silently drop writes. Every unimplemented index, every partial-width access and every access outside the decode region gets an error response and changes nothing.

The stored window and control values drive output ports at all times. A separate address translator reads them there.

Top module: `bwin_ctrl_regs`

## Requirements
- R1: While reset is low, `req_ready` and `rsp_valid` are low. After reset, `req_ready` is high. A request is accepted in a cycle where `req_valid` and `req_ready` are both high, and `rsp_valid` is high for exactly the following cycle.
- R2: Reset clears all twelve window registers to zero and loads the control register with 0x0000_0021_0010_0000 (bits 20 and 32 set, the 4-bit field at bit 36 equal to 2).
- R3: The register index is offset >> 6. Indices 0 to 3 are window bases 0 to 3, indices 4 to 7 are window masks 0 to 3, indices 8 to 11 are translated bases 0 to 3, and index 12 is the control register. A legal write stores all 64 data bits, a later read returns them, and the matching output port shows the new value from the cycle after acceptance.
- R4: Offset bits 5:0 are ignored, so any offset inside a 64-byte slot reaches that slot's register.
- R5: Index 15 (error status) reads as zero without error. A write to it completes without error and changes no state.
- R6: Index 16 (error mask) reads as zero without error. A write to it returns an error.
- R7: Index 19 (translation-cache invalidate-all) reads as zero. A write to it completes without error and changes no state.
- R8: Indices 13, 14, 17, 18, 20, 21 and every other unassigned index return an error on both read and write, and a write to them changes no register.
- R9: `req_size` is log2 of the access width in bytes. Any value other than 3 (8 bytes) returns an error and writes nothing.
- R10: An offset of 0xFFF or above returns an error and writes nothing, including offsets such as 0x1000 whose low bits alias a real register.
- R11: Every error response, and every write response, carries zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset from the block base |
| req_size | input | 2 | log2 of access width in bytes |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_err | output | 1 | Access error |
| rsp_rdata | output | 64 | Read data |
| win_base_o | output | 4x64 | Window base registers 0 to 3 |
| win_mask_o | output | 4x64 | Window mask registers 0 to 3 |
| win_xlat_o | output | 4x64 | Translated base registers 0 to 3 |
| ctl_o | output | 64 | Bridge control register |

## Verification
The bench addresses registers at offsets with nonzero low bits. A design that decoded those bits would miss the slot or flag an error. It writes to offset 0x1000 and reads offset 0x1300. A design that skipped the region check would alias these onto window base 0 and the control register and corrupt them. The bench treats the error-mask register differently for reads and writes, and sends partial-width writes. Afterwards it checks every exported register, so that an unimplemented or partial write that still reached storage would appear as a nonzero value on a port that should be zero or unchanged. A second reset in mid-run confirms that the control word returns to its nonzero pattern rather than to zero.

// File: rtl/bwin_pkg.sv
package bwin_pkg;
  localparam int unsigned NWIN  = 4;
  localparam int unsigned WIN_W = $clog2(NWIN);
  localparam int unsigned REG_W = 64;
  localparam int unsigned IDX_W = 6;

  // control word after reset: bit 20, bit 32, field at 36 = 2
  localparam logic [REG_W-1:0] CTL_RST =
    (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

  localparam logic [IDX_W-1:0] IDX_BASE0 = 6'd0;
  localparam logic [IDX_W-1:0] IDX_MASK0 = 6'd4;
  localparam logic [IDX_W-1:0] IDX_XLAT0 = 6'd8;
  localparam logic [IDX_W-1:0] IDX_CTL   = 6'd12;
  localparam logic [IDX_W-1:0] IDX_ESTAT = 6'd15;
  localparam logic [IDX_W-1:0] IDX_EMASK = 6'd16;
  localparam logic [IDX_W-1:0] IDX_INVAL = 6'd19;

  typedef enum logic [2:0] {
    K_NONE, K_ZERO, K_BASE, K_MASK, K_XLAT, K_CTL
  } kind_e;
endpackage

// File: rtl/bwin_decode.sv
module bwin_decode
  import bwin_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SLOT_SHIFT   = 6,
  parameter int unsigned REGION_BYTES = 32'hFFF,
  parameter int unsigned FULL_SIZE    = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  output kind_e             kind_o,
  output logic [WIN_W-1:0]  win_o,
  output logic              err_o
);
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] rel;
  logic             in_region;
  logic             full_width;

  assign idx        = addr_i[SLOT_SHIFT +: IDX_W];
  assign in_region  = (addr_i < ADDR_W'(REGION_BYTES));
  assign full_width = (size_i == 2'(FULL_SIZE));

  always_comb begin
    kind_o = K_NONE;
    rel    = '0;
    if (idx < IDX_MASK0) begin
      kind_o = K_BASE;
      rel    = idx - IDX_BASE0;
    end else if (idx < IDX_XLAT0) begin
      kind_o = K_MASK;
      rel    = idx - IDX_MASK0;
    end else if (idx < IDX_CTL) begin
      kind_o = K_XLAT;
      rel    = idx - IDX_XLAT0;
    end else if (idx == IDX_CTL) begin
      kind_o = K_CTL;
    end else if (idx == IDX_ESTAT || idx == IDX_INVAL) begin
      kind_o = K_ZERO;
    end else if (idx == IDX_EMASK) begin
      kind_o = write_i ? K_NONE : K_ZERO;
    end
  end

  assign win_o = rel[WIN_W-1:0];
  assign err_o = (kind_o == K_NONE) || !in_region || !full_width;
endmodule

// File: rtl/bwin_regfile.sv
module bwin_regfile
  import bwin_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  kind_e                       kind_i,
  input  logic [WIN_W-1:0]            win_i,
  input  logic [REG_W-1:0]            wdata_i,
  output logic [NWIN-1:0][REG_W-1:0]  base_o,
  output logic [NWIN-1:0][REG_W-1:0]  mask_o,
  output logic [NWIN-1:0][REG_W-1:0]  xlat_o,
  output logic [REG_W-1:0]            ctl_o,
  output logic [REG_W-1:0]            rd_data_o
);
  logic [NWIN-1:0] base_en, mask_en, xlat_en;
  logic            ctl_en;
  logic [REG_W-1:0] ctl_q;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic hit;
    logic [REG_W-1:0] base_q, mask_q, xlat_q;

    assign hit        = (win_i == WIN_W'(g));
    assign base_en[g] = we_i && hit && (kind_i == K_BASE);
    assign mask_en[g] = we_i && hit && (kind_i == K_MASK);
    assign xlat_en[g] = we_i && hit && (kind_i == K_XLAT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        mask_q <= '0;
        xlat_q <= '0;
      end else begin
        if (base_en[g]) base_q <= wdata_i;
        if (mask_en[g]) mask_q <= wdata_i;
        if (xlat_en[g]) xlat_q <= wdata_i;
      end
    end

    assign base_o[g] = base_q;
    assign mask_o[g] = mask_q;
    assign xlat_o[g] = xlat_q;
  end

  assign ctl_en = we_i && (kind_i == K_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= CTL_RST;
    else if (ctl_en) ctl_q <= wdata_i;
  end

  assign ctl_o = ctl_q;

  always_comb begin
    unique case (kind_i)
      K_BASE:  rd_data_o = base_o[win_i];
      K_MASK:  rd_data_o = mask_o[win_i];
      K_XLAT:  rd_data_o = xlat_o[win_i];
      K_CTL:   rd_data_o = ctl_q;
      default: rd_data_o = '0;
    endcase
  end

  // R3: at most one register is written per cycle
  a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({base_en, mask_en, xlat_en, ctl_en}));

  // R8: the control word moves only when a control write is accepted
  a_r8_ctl_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && kind_i == K_CTL) |=> $stable(ctl_q));
endmodule

// File: rtl/bwin_ctrl_regs.sv
module bwin_ctrl_regs
  import bwin_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SLOT_SHIFT   = 6,
  parameter int unsigned REGION_BYTES = 32'hFFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [1:0]                  req_size,
  input  logic [REG_W-1:0]            req_wdata,
  output logic                        rsp_valid,
  output logic                        rsp_err,
  output logic [REG_W-1:0]            rsp_rdata,
  output logic [NWIN-1:0][REG_W-1:0]  win_base_o,
  output logic [NWIN-1:0][REG_W-1:0]  win_mask_o,
  output logic [NWIN-1:0][REG_W-1:0]  win_xlat_o,
  output logic [REG_W-1:0]            ctl_o
);
  kind_e            kind;
  logic [WIN_W-1:0] win;
  logic             dec_err;
  logic             accept;
  logic             we;
  logic [REG_W-1:0] rd_data;

  logic             ready_q;
  logic             rsp_valid_d, rsp_valid_q;
  logic             rsp_err_d,   rsp_err_q;
  logic [REG_W-1:0] rsp_rdata_d, rsp_rdata_q;

  bwin_decode #(
    .ADDR_W       (ADDR_W),
    .SLOT_SHIFT   (SLOT_SHIFT),
    .REGION_BYTES (REGION_BYTES),
    .FULL_SIZE    (3)
  ) i_decode (
    .addr_i  (req_addr),
    .size_i  (req_size),
    .write_i (req_write),
    .kind_o  (kind),
    .win_o   (win),
    .err_o   (dec_err)
  );

  assign accept = req_valid && ready_q;
  assign we     = accept && req_write && !dec_err;

  bwin_regfile i_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (we),
    .kind_i    (kind),
    .win_i     (win),
    .wdata_i   (req_wdata),
    .base_o    (win_base_o),
    .mask_o    (win_mask_o),
    .xlat_o    (win_xlat_o),
    .ctl_o     (ctl_o),
    .rd_data_o (rd_data)
  );

  always_comb begin
    rsp_valid_d = accept;
    rsp_err_d   = accept && dec_err;
    rsp_rdata_d = (accept && !req_write && !dec_err) ? rd_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      ready_q     <= 1'b1;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      rsp_rdata_q <= rsp_rdata_d;
    end
  end

  assign req_ready = ready_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  // R1: a response appears only in the cycle after an acceptance
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  // R9: partial-width access always errors
  a_r9_partial_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_size != 2'd3) |=> rsp_err);

  // R10: offsets past the decode region always error
  a_r10_region_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr >= ADDR_W'(REGION_BYTES)) |=> rsp_err);

  // R11: error responses never carry data
  a_r11_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: tb/test_bwin_ctrl_regs.sv
`timescale 1ns/1ps
module test_bwin_ctrl_regs;
  import bwin_pkg::*;

  localparam logic [63:0] VA = 64'h0000_0000_8000_0003;
  localparam logic [63:0] VB = 64'h0000_0000_C000_0001;
  localparam logic [63:0] VC = 64'h0000_0000_0FF0_0000;
  localparam logic [63:0] VD = 64'h0000_0001_2340_0000;
  localparam logic [63:0] VE = 64'hDEAD_BEEF_0123_4567;
  localparam logic [63:0] VF = 64'h0000_0000_3FF0_0000;
  localparam logic [63:0] RST_CTL = 64'h0000_0021_0010_0000;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [1:0]  size;
    logic [63:0] wdata;
    logic        err;
    logic [63:0] rdata;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, 64'd0, 8'd2},        // R2 base0 zero
    '{1'b0, 16'h0300, 2'd3, 64'd0, 1'b0, RST_CTL, 8'd2},      // R2 control reset word
    '{1'b1, 16'h0000, 2'd3, VA, 1'b0, 64'd0, 8'd3},           // R3 write base0, R11 zero data
    '{1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, VA, 8'd3},           // R3
    '{1'b1, 16'h00C8, 2'd3, VB, 1'b0, 64'd0, 8'd4},           // R4 base3 via low bits
    '{1'b0, 16'h00C0, 2'd3, 64'd0, 1'b0, VB, 8'd4},           // R4
    '{1'b1, 16'h0140, 2'd3, VC, 1'b0, 64'd0, 8'd3},           // R3 mask1
    '{1'b0, 16'h017F, 2'd3, 64'd0, 1'b0, VC, 8'd4},           // R4 top byte of slot
    '{1'b1, 16'h02C0, 2'd3, VD, 1'b0, 64'd0, 8'd3},           // R3 xlat3
    '{1'b0, 16'h02C0, 2'd3, 64'd0, 1'b0, VD, 8'd3},           // R3
    '{1'b1, 16'h0300, 2'd3, VE, 1'b0, 64'd0, 8'd3},           // R3 control
    '{1'b0, 16'h0300, 2'd3, 64'd0, 1'b0, VE, 8'd3},           // R3
    '{1'b0, 16'h03C0, 2'd3, 64'd0, 1'b0, 64'd0, 8'd5},        // R5 read zero
    '{1'b1, 16'h03C0, 2'd3, '1, 1'b0, 64'd0, 8'd5},           // R5 write dropped
    '{1'b0, 16'h03C0, 2'd3, 64'd0, 1'b0, 64'd0, 8'd5},        // R5 still zero
    '{1'b0, 16'h0400, 2'd3, 64'd0, 1'b0, 64'd0, 8'd6},        // R6 read zero
    '{1'b1, 16'h0400, 2'd3, 64'h5, 1'b1, 64'd0, 8'd6},        // R6 write error
    '{1'b0, 16'h04C0, 2'd3, 64'd0, 1'b0, 64'd0, 8'd7},        // R7 read zero
    '{1'b1, 16'h04C0, 2'd3, '1, 1'b0, 64'd0, 8'd7},           // R7 write accepted
    '{1'b0, 16'h0340, 2'd3, 64'd0, 1'b1, 64'd0, 8'd8},        // R8 idx13
    '{1'b1, 16'h0380, 2'd3, 64'h11, 1'b1, 64'd0, 8'd8},       // R8 idx14
    '{1'b0, 16'h0440, 2'd3, 64'd0, 1'b1, 64'd0, 8'd8},        // R8 idx17
    '{1'b1, 16'h0480, 2'd3, 64'h22, 1'b1, 64'd0, 8'd8},       // R8 idx18
    '{1'b0, 16'h0500, 2'd3, 64'd0, 1'b1, 64'd0, 8'd8},        // R8 idx20
    '{1'b1, 16'h0540, 2'd3, 64'h33, 1'b1, 64'd0, 8'd8},       // R8 idx21
    '{1'b0, 16'h0580, 2'd3, 64'd0, 1'b1, 64'd0, 8'd8},        // R8 idx22
    '{1'b0, 16'h0FC0, 2'd3, 64'd0, 1'b1, 64'd0, 8'd8},        // R8 idx63
    '{1'b1, 16'h0000, 2'd2, 64'h55, 1'b1, 64'd0, 8'd9},       // R9 4-byte write
    '{1'b0, 16'h0000, 2'd0, 64'd0, 1'b1, 64'd0, 8'd9},        // R9 1-byte read
    '{1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, VA, 8'd9},           // R9 base0 intact
    '{1'b1, 16'h1000, 2'd3, 64'h77, 1'b1, 64'd0, 8'd10},      // R10 alias of base0
    '{1'b0, 16'h0000, 2'd3, 64'd0, 1'b0, VA, 8'd10},          // R10 base0 intact
    '{1'b0, 16'h0FFF, 2'd3, 64'd0, 1'b1, 64'd0, 8'd10},       // R10 last byte
    '{1'b0, 16'h1300, 2'd3, 64'd0, 1'b1, 64'd0, 8'd10},       // R10 alias of control
    '{1'b1, 16'h0104, 2'd3, VF, 1'b0, 64'd0, 8'd3},           // R3 mask0
    '{1'b0, 16'h0100, 2'd3, 64'd0, 1'b0, VF, 8'd3}            // R3
  };

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [15:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic rsp_valid, rsp_err;
  logic [63:0] rsp_rdata;
  logic [NWIN-1:0][63:0] win_base, win_mask, win_xlat;
  logic [63:0] ctl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bwin_ctrl_regs i_bwin_ctrl_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err),
    .rsp_rdata  (rsp_rdata),
    .win_base_o (win_base),
    .win_mask_o (win_mask),
    .win_xlat_o (win_xlat),
    .ctl_o      (ctl)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic access(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = v.wr;
    req_addr  = v.addr;
    req_size  = v.size;
    req_wdata = v.wdata;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid === 1'b1 && rsp_err === v.err && rsp_rdata === v.rdata,
        $sformatf("R%0d addr=%h", v.rq, v.addr),
        {rsp_valid, rsp_err, rsp_rdata[61:0]},
        {1'b1, v.err, v.rdata[61:0]});
  endtask

  task automatic chk_reset_ports(input string tag);
    for (int w = 0; w < NWIN; w++) begin
      chk(win_base[w] === 64'd0, {"R2 base ", tag}, win_base[w], 64'd0);
      chk(win_mask[w] === 64'd0, {"R2 mask ", tag}, win_mask[w], 64'd0);
      chk(win_xlat[w] === 64'd0, {"R2 xlat ", tag}, win_xlat[w], 64'd0);
    end
    chk(ctl === RST_CTL, {"R2 ctl ", tag}, ctl, RST_CTL);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_size = 2'd3; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: ready and response held low in reset
    chk(req_ready === 1'b0 && rsp_valid === 1'b0, "R1 reset handshake",
        {req_ready, rsp_valid}, 64'd0);
    chk_reset_ports("first reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", req_ready, 64'd1);

    for (int i = 0; i < NV; i++) access(VECS[i]);

    @(negedge clk);
    // R1: single-cycle response
    chk(rsp_valid === 1'b0, "R1 response lasts one cycle", rsp_valid, 64'd0);

    // R3: exported values; R8/R9/R10: nothing else written
    chk(win_base[0] === VA, "R3 port base0", win_base[0], VA);
    chk(win_base[3] === VB, "R4 port base3", win_base[3], VB);
    chk(win_mask[0] === VF, "R3 port mask0", win_mask[0], VF);
    chk(win_mask[1] === VC, "R3 port mask1", win_mask[1], VC);
    chk(win_xlat[3] === VD, "R3 port xlat3", win_xlat[3], VD);
    chk(ctl === VE, "R3 port ctl", ctl, VE);
    chk(win_base[1] === 64'd0 && win_base[2] === 64'd0, "R8 base1/2 untouched",
        win_base[1] | win_base[2], 64'd0);
    chk(win_mask[2] === 64'd0 && win_mask[3] === 64'd0, "R8 mask2/3 untouched",
        win_mask[2] | win_mask[3], 64'd0);
    chk((win_xlat[0] | win_xlat[1] | win_xlat[2]) === 64'd0,
        "R5 R7 xlat0-2 untouched", win_xlat[0] | win_xlat[1] | win_xlat[2], 64'd0);

    // R2: second reset restores the nonzero control pattern
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(req_ready === 1'b0, "R1 ready drops in reset", req_ready, 64'd0);
    chk_reset_ports("second reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    access('{1'b0, 16'h0300, 2'd3, 64'd0, 1'b0, RST_CTL, 8'd2});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule